// File: doc/BRIEF.md
# Indexed Configuration Port with Device-ID Unlock

This block lets a host on a local bus reach the configuration registers of a dual-channel disk controller through only two byte-wide ports. The host writes a register number to the index port and then reads or writes the selected register through the data port. The port pair sits at 0x078/0x07C or at 0x178/0x17C. A strap sampled at reset picks the pair, and only address bits 8:0 are compared.

A second strap, sampled at reset, turns on a lock. While the lock is on, each data-port access drops the block out of configuration mode. The host must then write the chip's device identifier (0x60 plus a 2-bit instance number) to the index port before it can pick a new register. The block keeps the controller-owned registers 0x50 to 0x59 and applies a write mask to each one. It also keeps an interrupt-pending flag that the channel logic sets and that a data-port read of register 0x50 clears. It gives the channel decoder the value of register 0x51 and a strobe that pulses each time that register is written.

A request may be 8, 16 or 32 bits wide. The block splits it into byte accesses at consecutive addresses, lowest first, one per clock. Each byte obeys the same port rules.

Top module: `idx_cfg_port`

## Requirements
- R1: After reset the block is in configuration mode with index 0x00. Register 0x59 holds 0x40 and registers 0x51 to 0x58 hold 0x00. Register 0x50 holds the lock strap in bit 7, 0 in bit 6, the base strap in bit 5, the instance number in bits 4:3, 0 in the pending bit 2, and 3'b010 in bits 2:0.
- R2: The index port is at base+0 and the data port at base+4. The base is 0x078 when register 0x50 bit 5 is 0 and 0x178 when it is 1. Address bits above bit 8 are ignored. Reads of any other address return 0xFF, and writes to them change nothing.
- R3: A read of the index port returns the current index in configuration mode and 0xFF outside it.
- R4: Outside configuration mode, an index-port write equal to 0x60 plus the instance number enters configuration mode and leaves the index unchanged. Any other value is ignored.
- R5: When the lock bit (register 0x50 bit 7) is set, any data-port read or write leaves configuration mode. When it is clear, the block stays in configuration mode. Index-port reads never change the mode.
- R6: In configuration mode an index-port write loads the index. A data-port access reaches the indexed register whether or not the block is in configuration mode. Indices outside 0x50 to 0x59 read 0x00 and ignore writes, and register 0x50 ignores writes.
- R7: Data writes are masked per register. 0x53 and 0x55 keep bits 7:6 (mask 0xC0), 0x57 keeps mask 0xDC, and 0x51, 0x52, 0x54, 0x56, 0x58 and 0x59 are fully writable.
- R8: A data write to register 0x51 updates `chanCtrl` and pulses `decodeUpdate` for one cycle, in the same cycle that `done` is high for a one-byte write. Writes to other registers do not pulse it.
- R9: A pulse on `irqSet` sets register 0x50 bit 2. A data-port read of register 0x50 returns the value with the bit still set, and then clears it.
- R10: `reqSize` 0, 1 and 2 (or 3) give 1, 2 and 4 byte accesses at reqAddr+k. Read byte k lands in rdata bits 8k+7:8k and the unused upper bytes are 0. `done` is a one-cycle pulse after the last byte. While `busy` is high, new requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, straps sampled |
| lockStrap | input | 1 | Power-up value of the lock bit |
| highBaseStrap | input | 1 | Power-up base select (1 = 0x178) |
| irqSet | input | 1 | Channel interrupt event, sets the pending flag |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | 0 byte, 1 16-bit, 2/3 32-bit |
| reqAddr | input | ADDR_W | Port address of the lowest byte |
| reqWdata | input | DATA_W | Write data, byte k at bits 8k+7:8k |
| busy | output | 1 | Byte accesses in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Assembled read data, valid with done |
| chanCtrl | output | 8 | Current value of register 0x51 |
| decodeUpdate | output | 1 | Pulse on a write to register 0x51 |

## Verification
The bench targets the lock sequence, in several ways:
- It writes a wrong identifier and a plain index while locked out. A design that accepted either would show a changed index once unlocked.
- It writes the identifier in the low byte of a 16-bit write. A design that also took the high byte as an index would read back the wrong index.
- It checks that a data write and a data read both end configuration mode, and that the mode survives data accesses when the lock is off.
- It checks that a read of register 0x50 still shows the pending flag and that the next read does not, which catches a design that cleared the flag too early.
- It applies write masks and aliased addresses, and issues a request while busy. A design that mishandled any of these would corrupt register values or the index.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;
  localparam int DEC_W = 9;
  localparam logic [7:0] IDX_OFF = 8'h78;
  localparam logic [7:0] DATA_OFF = 8'h7C;
  localparam logic [7:0] REG_BASE = 8'h50;
  localparam int REG_COUNT = 10;
  localparam logic [7:0] CHAN_REG = 8'h51;
  localparam int LOCK_BIT = 7;
  localparam int HIGH_BIT = 5;
  localparam int PEND_BIT = 2;
  localparam logic [7:0] ID_BASE = 8'h60;
  localparam logic [2:0] REVISION = 3'b010;

  typedef struct packed {
    logic acc;
    logic wr;
    logic [DEC_W-1:0] addr;
    logic [7:0] wdata;
  } portStrobe_t;

  function automatic logic [7:0] writeMask(input int off);
    case (off)
      1, 2, 4, 6, 8, 9: writeMask = 8'hFF;
      3, 5: writeMask = 8'hC0;
      7: writeMask = 8'hDC;
      default: writeMask = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] resetValue(input int off);
    resetValue = (off == 9) ? 8'h40 : 8'h00;
  endfunction
endpackage

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgport_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [7:0]        rbyte,
  output portStrobe_t       strobe,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int BYTES = DATA_W / 8;
  localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1;

  logic              active;
  logic              isWr;
  logic [IDX_W-1:0]  byteIdx;
  logic [IDX_W-1:0]  lastIdx;
  logic [ADDR_W-1:0] addrL;
  logic [DATA_W-1:0] wdataL;
  logic [DATA_W-1:0] accum;
  logic [ADDR_W-1:0] curAddr;
  logic [IDX_W-1:0]  sizeLast;

  always_comb begin
    case (reqSize)
      2'd0: sizeLast = '0;
      2'd1: sizeLast = IDX_W'(1);
      default: sizeLast = IDX_W'(BYTES - 1);
    endcase
  end

  assign curAddr = addrL + ADDR_W'(byteIdx);

  always_comb begin
    strobe.acc = active;
    strobe.wr = isWr;
    strobe.addr = curAddr[DEC_W-1:0];
    strobe.wdata = wdataL[8*byteIdx +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      done <= 1'b0;
      isWr <= 1'b0;
      byteIdx <= '0;
      lastIdx <= '0;
      addrL <= '0;
      wdataL <= '0;
      accum <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (reqValid) begin
          active <= 1'b1;
          isWr <= reqWrite;
          byteIdx <= '0;
          lastIdx <= sizeLast;
          addrL <= reqAddr;
          wdataL <= reqWdata;
          accum <= '0;
        end
      end else begin
        if (!isWr) accum[8*byteIdx +: 8] <= rbyte;
        if (byteIdx == lastIdx) begin
          active <= 1'b0;
          done <= 1'b1;
        end else begin
          byteIdx <= byteIdx + 1'b1;
        end
      end
    end
  end

  assign busy = active;
  assign rdata = accum;
endmodule

// File: rtl/cfgport_dp.sv
module cfgport_dp
  import cfgport_pkg::*;
#(
  parameter logic [1:0] INSTANCE = 2'd0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        lockStrap,
  input  logic        highBaseStrap,
  input  logic        irqSet,
  input  portStrobe_t strobe,
  output logic [7:0]  rbyte,
  output logic [7:0]  chanCtrl,
  output logic        decodeUpdate,
  output logic        cfgMode,
  output logic        lockOn
);
  localparam logic [7:0] DEV_ID = ID_BASE | {6'd0, INSTANCE};
  localparam int OFF_W = $clog2(REG_COUNT);

  logic [7:0] regVal [REG_COUNT];
  logic [7:0] index;
  logic [7:0] offFull;
  logic [OFF_W-1:0] regOff;
  logic inWindow;
  logic [DEC_W-1:0] baseAddr;
  logic isIdx, isData, dataWr, dataRd;

  assign lockOn = regVal[0][LOCK_BIT];
  assign baseAddr = {regVal[0][HIGH_BIT], IDX_OFF};
  assign isIdx = strobe.addr == baseAddr;
  assign isData = strobe.addr == {regVal[0][HIGH_BIT], DATA_OFF};
  assign dataWr = strobe.acc && strobe.wr && isData;
  assign dataRd = strobe.acc && !strobe.wr && isData;
  assign offFull = index - REG_BASE;
  assign inWindow = offFull < 8'(REG_COUNT);
  assign regOff = offFull[OFF_W-1:0];

  always_comb begin
    if (isIdx) rbyte = cfgMode ? index : 8'hFF;
    else if (isData) rbyte = inWindow ? regVal[regOff] : 8'h00;
    else rbyte = 8'hFF;
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : gReg
    logic [7:0] q;
    if (g == 0) begin : gStatus
      logic clrPend;
      assign clrPend = dataRd && (index == REG_BASE);
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= {lockStrap, 1'b0, highBaseStrap, INSTANCE, REVISION};
        end else if (irqSet) begin
          q[PEND_BIT] <= 1'b1;
        end else if (clrPend) begin
          q[PEND_BIT] <= 1'b0;
        end
      end
    end else begin : gPlain
      always_ff @(posedge clk) begin
        if (rst) q <= resetValue(g);
        else if (dataWr && index == REG_BASE + 8'(g)) q <= strobe.wdata & writeMask(g);
      end
    end
    assign regVal[g] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgMode <= 1'b1;
      index <= 8'h00;
      decodeUpdate <= 1'b0;
    end else begin
      decodeUpdate <= dataWr && (index == CHAN_REG);
      if (strobe.acc && strobe.wr && isIdx) begin
        if (cfgMode) index <= strobe.wdata;
        else if (lockOn && strobe.wdata == DEV_ID) cfgMode <= 1'b1;
      end
      if (strobe.acc && isData && lockOn) cfgMode <= 1'b0;
    end
  end

  assign chanCtrl = regVal[1];
endmodule

// File: rtl/idx_cfg_port.sv
module idx_cfg_port
  import cfgport_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter logic [1:0] INSTANCE = 2'd0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lockStrap,
  input  logic              highBaseStrap,
  input  logic              irqSet,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [7:0]        chanCtrl,
  output logic              decodeUpdate
);
  portStrobe_t strobe;
  logic [7:0] rbyte;
  logic cfgMode;
  logic lockOn;

  cfgport_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rbyte(rbyte), .strobe(strobe), .busy(busy), .done(done), .rdata(rdata)
  );

  cfgport_dp #(.INSTANCE(INSTANCE)) uDp (
    .clk(clk), .rst(rst), .lockStrap(lockStrap), .highBaseStrap(highBaseStrap),
    .irqSet(irqSet), .strobe(strobe), .rbyte(rbyte), .chanCtrl(chanCtrl),
    .decodeUpdate(decodeUpdate), .cfgMode(cfgMode), .lockOn(lockOn)
  );
endmodule

// File: rtl/idx_cfg_port_chk.sv
module idx_cfg_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic [7:0] chanCtrl,
  input logic       decodeUpdate,
  input logic       cfgMode,
  input logic       lockOn
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst) !(busy && done));
  // R8
  update_source_chk: assert property (@(posedge clk) disable iff (rst) decodeUpdate |-> $past(busy));
  // R8
  chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !decodeUpdate |-> chanCtrl == $past(chanCtrl));
  // R5
  unlocked_stays_chk: assert property (@(posedge clk) disable iff (rst) !lockOn |-> cfgMode);
  // R4
  enter_from_access_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfgMode) |-> $past(busy));
endmodule

bind idx_cfg_port idx_cfg_port_chk uChk (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .chanCtrl(chanCtrl),
  .decodeUpdate(decodeUpdate), .cfgMode(cfgMode), .lockOn(lockOn)
);

// File: tb/idx_cfg_port_test.sv
`timescale 1ns/1ps
module idx_cfg_port_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lockStrap = 1'b0, highBaseStrap = 1'b0, irqSet = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0] reqSize = 2'd0;
  logic [9:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic busy, done, decodeUpdate;
  logic [31:0] rdata;
  logic [7:0] chanCtrl;
  int testsRun = 0, testsFailed = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  idx_cfg_port #(.ADDR_W(10), .DATA_W(32), .INSTANCE(2'd1)) uut (
    .clk(clk), .rst(rst), .lockStrap(lockStrap), .highBaseStrap(highBaseStrap),
    .irqSet(irqSet), .reqValid(reqValid), .reqWrite(reqWrite), .reqSize(reqSize),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busy(busy), .done(done),
    .rdata(rdata), .chanCtrl(chanCtrl), .decodeUpdate(decodeUpdate)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic doReset(input logic lk, input logic hi);
    @(negedge clk);
    rst = 1'b1; lockStrap = lk; highBaseStrap = hi;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic access(input logic wr, input logic [1:0] sz, input logic [9:0] a,
                        input logic [31:0] wd, output logic [31:0] rd, output logic upd);
    upd = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqAddr = a; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    while (!done) begin
      upd = upd | decodeUpdate;
      @(negedge clk);
    end
    upd = upd | decodeUpdate;
    rd = rdata;
  endtask

  task automatic wr8(input logic [9:0] a, input logic [7:0] v);
    logic [31:0] r; logic u;
    access(1'b1, 2'd0, a, {24'd0, v}, r, u);
  endtask

  task automatic rd8(input logic [9:0] a, output logic [7:0] v);
    logic [31:0] r; logic u;
    access(1'b0, 2'd0, a, 32'd0, r, u);
    v = r[7:0];
  endtask

  task automatic testReset();
    logic [7:0] v;
    doReset(1'b0, 1'b0);
    check("R1 busy/done idle", {30'd0, busy, done}, 32'd0);
    rd8(10'h078, v); check("R1 R3 index after reset", v, 8'h00);
    rd8(10'h07C, v); check("R6 reg 0x00 outside window", v, 8'h00);
    wr8(10'h078, 8'h50);
    rd8(10'h07C, v); check("R1 status reset unlocked", v, 8'h0A);
    wr8(10'h078, 8'h59);
    rd8(10'h07C, v); check("R1 reg59 reset", v, 8'h40);
    rd8(10'h07A, v); check("R2 undecoded read", v, 8'hFF);
    rd8(10'h178, v); check("R2 high pair unused in low mode", v, 8'hFF);
    wr8(10'h278, 8'h52);
    rd8(10'h078, v); check("R2 bit9 alias of index port", v, 8'h52);
    rd8(10'h07C, v); check("R1 reg52 reset", v, 8'h00);
  endtask

  task automatic testMasks();
    logic [7:0] v;
    wr8(10'h078, 8'h53); wr8(10'h07C, 8'hFF);
    rd8(10'h07C, v); check("R7 reg53 mask", v, 8'hC0);
    wr8(10'h078, 8'h57); wr8(10'h07C, 8'hFF);
    rd8(10'h07C, v); check("R7 reg57 mask", v, 8'hDC);
    wr8(10'h078, 8'h52); wr8(10'h07C, 8'hA5);
    rd8(10'h07C, v); check("R7 reg52 full", v, 8'hA5);
    wr8(10'h078, 8'h10); wr8(10'h07C, 8'h55);
    rd8(10'h07C, v); check("R6 out-of-window write ignored", v, 8'h00);
    wr8(10'h078, 8'h50); wr8(10'h07C, 8'hFF);
    rd8(10'h07C, v); check("R6 reg50 write ignored", v, 8'h0A);
    wr8(10'h07A, 8'h33);
    rd8(10'h078, v); check("R2 R5 undecoded write ignored, still in mode", v, 8'h50);
  endtask

  task automatic testDecode();
    logic [31:0] r; logic u;
    wr8(10'h078, 8'h51);
    access(1'b1, 2'd0, 10'h07C, 32'h3C, r, u);
    check("R8 update pulse with done", {31'd0, decodeUpdate}, 32'd1);
    check("R8 chanCtrl value", {24'd0, chanCtrl}, 32'h3C);
    @(negedge clk);
    check("R8 pulse is one cycle", {31'd0, decodeUpdate}, 32'd0);
    wr8(10'h078, 8'h52);
    access(1'b1, 2'd0, 10'h07C, 32'h77, r, u);
    check("R8 no pulse for reg52", {31'd0, u}, 32'd0);
    check("R8 chanCtrl held", {24'd0, chanCtrl}, 32'h3C);
  endtask

  task automatic testIrq();
    logic [7:0] v;
    wr8(10'h078, 8'h50);
    @(negedge clk); irqSet = 1'b1;
    @(negedge clk); irqSet = 1'b0;
    rd8(10'h07C, v); check("R9 pending visible", v, 8'h0E);
    rd8(10'h07C, v); check("R9 pending cleared by read", v, 8'h0A);
  endtask

  task automatic testLock();
    logic [7:0] v;
    doReset(1'b1, 1'b1);
    rd8(10'h178, v); check("R1 locked part starts in mode", v, 8'h00);
    wr8(10'h178, 8'h50);
    rd8(10'h17C, v); check("R1 status reset locked high", v, 8'hAA);
    rd8(10'h178, v); check("R5 R3 data read exits mode", v, 8'hFF);
    wr8(10'h178, 8'h52);
    wr8(10'h178, 8'h60);
    rd8(10'h178, v); check("R4 wrong values ignored", v, 8'hFF);
    wr8(10'h178, 8'h61);
    rd8(10'h178, v); check("R4 id unlocks, index kept", v, 8'h50);
    rd8(10'h178, v); check("R5 index read keeps mode", v, 8'h50);
    wr8(10'h178, 8'h59);
    wr8(10'h17C, 8'h12);
    rd8(10'h178, v); check("R5 data write exits mode", v, 8'hFF);
    rd8(10'h17C, v); check("R6 data access while locked out", v, 8'h12);
    rd8(10'h078, v); check("R2 low pair unused in high mode", v, 8'hFF);
  endtask

  task automatic testWide();
    logic [31:0] r; logic u; logic [7:0] v;
    access(1'b1, 2'd1, 10'h178, 32'h5361, r, u);
    rd8(10'h178, v); check("R10 high byte not an index write", v, 8'h59);
    access(1'b1, 2'd1, 10'h177, 32'h5300, r, u);
    access(1'b0, 2'd2, 10'h178, 32'd0, r, u);
    check("R10 32-bit read over index port", r, 32'hFFFFFF53);
    access(1'b0, 2'd1, 10'h17B, 32'd0, r, u);
    check("R10 16-bit read reaching data port", r, 32'h000000FF);
    rd8(10'h178, v); check("R10 R5 byte rules per byte", v, 8'hFF);
  endtask

  task automatic testBusy();
    logic [7:0] v;
    wr8(10'h178, 8'h61);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqSize = 2'd2; reqAddr = 10'h178;
    @(negedge clk);
    reqWrite = 1'b1; reqSize = 2'd0; reqWdata = 32'h11;
    check("R10 busy during access", {31'd0, busy}, 32'd1);
    @(negedge clk);
    reqValid = 1'b0;
    while (!done) @(negedge clk);
    check("R10 read while intruded", rdata, 32'hFFFFFF53);
    @(negedge clk);
    check("R10 done one cycle", {31'd0, done}, 32'd0);
    rd8(10'h178, v); check("R10 request while busy ignored", v, 8'h53);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    testReset();
    testMasks();
    testDecode();
    testIrq();
    testLock();
    testWide();
    testBusy();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule